// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block is a timed state machine that brings an analog PHY out of power-down in a fixed order. When a power-on request arrives, it first forces both analog controls low: the power-down-bar line (`pdb`) and the DLL enable (`endll`). It holds them low for a settling interval and then raises `pdb`. After a pad calibration wait it samples the calibration-done flag once. If that flag is set, it raises `endll`, waits for DLL lock, and samples the DLL-ready flag once. A power-off request drops both controls at once and completes with no waiting.

All waits are whole numbers of microseconds. They are converted to clock cycles through a cycles-per-microsecond parameter. Each wait runs for exactly its full cycle count. A flag that is not set when it is sampled ends the sequence with a one-cycle error pulse and a stage code. The controls keep the values they had when the error occurred. The frequency-select and drive-strength fields of the PHY are programmed by the register side before a power-on request. This block does not drive them.

Top module: `phy_bringup_seq`

## Requirements
- R1: When idle (`busy` low), an `on_req` with `off_req` low is accepted. On the next cycle `busy` is high and both `pdb` and `endll` are low, even if they were high before.
- R2: When idle, `off_req` drives `pdb` and `endll` low on the next cycle. In that same cycle `done` pulses high for exactly one cycle, and `busy` stays low. If `on_req` and `off_req` arrive together while idle, the off request wins.
- R3: After a power-on request is accepted, `pdb` first goes high SETTLE_US×CYCLES_PER_US cycles after `busy` rises. `pdb` stays low before that, and `endll` stays low throughout the settling interval.
- R4: `caldone` is sampled only in the CAL_US×CYCLES_PER_US-th cycle in which `pdb` is high. Its value in earlier cycles has no effect. If the sampled value is 0, the sequencer returns to idle and pulses `err` for one cycle with `err_code` = 2'b01. `pdb` stays high and `endll` stays low.
- R5: If the sampled `caldone` is 1, `endll` rises on the next cycle and `pdb` stays high.
- R6: `dllrdy` is sampled in the DLL_US×CYCLES_PER_US-th cycle in which `endll` is high. If it is 1, `done` pulses for one cycle and `busy` falls, with `pdb` and `endll` left high.
- R7: If the sampled `dllrdy` is 0, the sequencer returns to idle and pulses `err` for one cycle with `err_code` = 2'b10. `pdb` and `endll` both stay high.
- R8: `on_req` and `off_req` have no effect while `busy` is high. The controls and the timing of the sequence in progress do not change, and no `done` pulse results.
- R9: `err_code` is 2'b00 whenever `err` is low. `done` and `err` are never high in the same cycle. `endll` is never high while `pdb` is low.
- R10: While and after reset, `pdb`, `endll`, `busy`, `done` and `err` are low and `err_code` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| on_req | input | 1 | Power-on request, sampled when idle |
| off_req | input | 1 | Power-off request, sampled when idle; wins over on_req |
| caldone | input | 1 | Pad calibration finished flag from the PHY |
| dllrdy | input | 1 | DLL locked flag from the PHY |
| pdb | output | 1 | Power-down-bar control to the PHY analog blocks |
| endll | output | 1 | DLL enable control to the PHY |
| busy | output | 1 | High while a power-on sequence is in progress |
| done | output | 1 | One-cycle pulse when a request completes successfully |
| err | output | 1 | One-cycle pulse when a status check fails |
| err_code | output | 2 | Failing stage: 01 calibration, 10 DLL, 00 when err is low |

## Verification
The assertions check the following on every cycle:
- the immediate effect of an accepted request on the controls and on `busy`;
- that an off request completes in a single cycle;
- that `endll` never runs ahead of `pdb`;
- that `done` and `err` are exclusive, and that `err_code` is zero outside an error;
- that `pdb` rises only out of a busy sequence.

Some behaviour only the bench scenarios can show. These are the exact cycle counts of each wait, and that a flag is read only in the final cycle of its wait (shown by a late-rising `caldone`). They also include each error leaving the controls where they were, and requests during a sequence being ignored without shifting its timing.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CAL    = 2'd2,
        ST_DLL    = 2'd3
    } seq_state_e;

    localparam logic [1:0] ERR_NONE = 2'b00;
    localparam logic [1:0] ERR_CAL  = 2'b01;
    localparam logic [1:0] ERR_DLL  = 2'b10;

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: every wait is at least two cycles long, so a fresh load is never zero
    a_r3_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
    import phy_bringup_pkg::*;
#(
    parameter int W        = 8,
    parameter int SETTLE_N = 3,
    parameter int CAL_N    = 5,
    parameter int DLL_N    = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         on_req,
    input  logic         off_req,
    input  logic         caldone,
    input  logic         dllrdy,
    input  logic         tmr_expired,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         pdb,
    output logic         endll,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [1:0]   err_code
);
    typedef struct packed {
        seq_state_e state;
        logic       pdb;
        logic       endll;
        logic       done;
        logic       err;
        logic [1:0] code;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        r_d.code = ERR_NONE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (off_req) begin
                    r_d.pdb   = 1'b0;
                    r_d.endll = 1'b0;
                    r_d.done  = 1'b1;
                end else if (on_req) begin
                    r_d.pdb   = 1'b0;
                    r_d.endll = 1'b0;
                    r_d.state = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = W'(SETTLE_N - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    r_d.pdb   = 1'b1;
                    r_d.state = ST_CAL;
                    tmr_load  = 1'b1;
                    tmr_val   = W'(CAL_N - 1);
                end
            end
            ST_CAL: begin
                if (tmr_expired) begin
                    if (caldone) begin
                        r_d.endll = 1'b1;
                        r_d.state = ST_DLL;
                        tmr_load  = 1'b1;
                        tmr_val   = W'(DLL_N - 1);
                    end else begin
                        r_d.err   = 1'b1;
                        r_d.code  = ERR_CAL;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_DLL: begin
                if (tmr_expired) begin
                    r_d.state = ST_IDLE;
                    if (dllrdy) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.err  = 1'b1;
                        r_d.code = ERR_DLL;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, pdb: 1'b0, endll: 1'b0,
                     done: 1'b0, err: 1'b0, code: ERR_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign pdb      = r_q.pdb;
    assign endll    = r_q.endll;
    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign err_code = r_q.code;

    // R1: an accepted power-on request starts with both controls low
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (on_req && !off_req && !busy) |=> (busy && !pdb && !endll));

    // R2: an idle power-off request completes in one cycle
    a_r2_off_now: assert property (@(posedge clk) disable iff (!rst_n)
        (off_req && !busy) |=> (!pdb && !endll && done && !busy));

    // R3: pdb can only rise out of a running sequence
    a_r3_pdb_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdb) |-> $past(busy));

    // R9: completion and error are exclusive
    a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    // R9: stage code only during an error pulse
    a_r9_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (err_code == ERR_NONE));

    // R9: an error always names a stage
    a_r9_code_set: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != ERR_NONE));

    // R9: DLL enable never without power
    a_r9_endll_needs_pdb: assert property (@(posedge clk) disable iff (!rst_n)
        endll |-> pdb);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
    parameter int CYCLES_PER_US = 250,
    parameter int SETTLE_US     = 3,
    parameter int CAL_US        = 5,
    parameter int DLL_US        = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_req,
    input  logic       off_req,
    input  logic       caldone,
    input  logic       dllrdy,
    output logic       pdb,
    output logic       endll,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [1:0] err_code
);
    localparam int SETTLE_N = SETTLE_US * CYCLES_PER_US;
    localparam int CAL_N    = CAL_US * CYCLES_PER_US;
    localparam int DLL_N    = DLL_US * CYCLES_PER_US;
    localparam int MAX_A    = (SETTLE_N > CAL_N) ? SETTLE_N : CAL_N;
    localparam int MAX_N    = (MAX_A > DLL_N) ? MAX_A : DLL_N;
    localparam int W        = $clog2(MAX_N + 1);

    logic         tmr_load;
    logic [W-1:0] tmr_val;
    logic         tmr_expired;

    phy_seq_timer #(.W(W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    phy_seq_ctrl #(
        .W        (W),
        .SETTLE_N (SETTLE_N),
        .CAL_N    (CAL_N),
        .DLL_N    (DLL_N)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .on_req      (on_req),
        .off_req     (off_req),
        .caldone     (caldone),
        .dllrdy      (dllrdy),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .pdb         (pdb),
        .endll       (endll),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .err_code    (err_code)
    );

    initial begin
        a_r3_waits_long: assert (SETTLE_N >= 2 && CAL_N >= 2 && DLL_N >= 2);
    end

endmodule

// File: tb/phy_bringup_seq_test.sv
`timescale 1ns/1ps
module phy_bringup_seq_test;
    localparam int CPU      = 4;
    localparam int SETTLE_N = 3 * CPU;
    localparam int CAL_N    = 5 * CPU;
    localparam int DLL_N    = 30 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_req = 1'b0, off_req = 1'b0, caldone = 1'b0, dllrdy = 1'b0;
    logic pdb, endll, busy, done, err;
    logic [1:0] err_code;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    phy_bringup_seq #(.CYCLES_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
        .caldone(caldone), .dllrdy(dllrdy), .pdb(pdb), .endll(endll),
        .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    // vector fields: {caldone, dllrdy, expected err_code[1:0]}
    localparam logic [3:0] VEC [4] = '{4'b1100, 4'b0001, 4'b1010, 4'b1100};

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_on(input logic cal_v, input logic dll_v,
                          input logic [1:0] exp_code,
                          input bit late_cal, input bit poke);
        @(negedge clk);
        on_req  = 1'b1;
        caldone = late_cal ? 1'b0 : cal_v;
        dllrdy  = dll_v;
        @(negedge clk);
        on_req = 1'b0;
        check("R1 busy", busy, 1);
        check("R1 pdb low", pdb, 0);
        check("R1 endll low", endll, 0);
        for (int i = 1; i < SETTLE_N; i++) begin
            if (poke && i == 4) begin on_req = 1'b1; off_req = 1'b1; end
            @(negedge clk);
            if (poke && i == 4) begin
                on_req = 1'b0; off_req = 1'b0;
                check("R8 no done", done, 0);
                check("R8 busy kept", busy, 1);
                check("R8 pdb kept", pdb, 0);
            end
        end
        check("R3 pdb still low", pdb, 0);
        @(negedge clk);
        check("R3 pdb up", pdb, 1);
        check("R3 endll low", endll, 0);
        for (int i = 1; i < CAL_N; i++) @(negedge clk);
        check("R4 waiting endll", endll, 0);
        check("R4 waiting busy", busy, 1);
        if (late_cal) caldone = 1'b1;
        @(negedge clk);
        if (late_cal) caldone = 1'b0;
        if (exp_code == 2'b01) begin
            check("R4 err", err, 1);
            check("R4 code", err_code, 1);
            check("R4 pdb kept", pdb, 1);
            check("R4 endll kept", endll, 0);
            check("R4 idle", busy, 0);
            @(negedge clk);
            check("R9 err pulse", err, 0);
            check("R9 code clear", err_code, 0);
            return;
        end
        check("R5 endll up", endll, 1);
        check("R5 pdb kept", pdb, 1);
        check("R5 no err", err, 0);
        for (int i = 1; i < DLL_N; i++) @(negedge clk);
        check("R6 waiting done", done, 0);
        check("R6 waiting busy", busy, 1);
        @(negedge clk);
        if (exp_code == 2'b10) begin
            check("R7 err", err, 1);
            check("R7 code", err_code, 2);
            check("R7 pdb kept", pdb, 1);
            check("R7 endll kept", endll, 1);
            check("R7 idle", busy, 0);
        end else begin
            check("R6 done", done, 1);
            check("R6 idle", busy, 0);
            check("R6 pdb", pdb, 1);
            check("R6 endll", endll, 1);
            check("R6 err", err, 0);
        end
        @(negedge clk);
        check("R6 done pulse", done, 0);
        check("R9 err clear", err, 0);
    endtask

    task automatic run_off(input logic with_on);
        @(negedge clk);
        off_req = 1'b1;
        on_req  = with_on;
        @(negedge clk);
        off_req = 1'b0;
        on_req  = 1'b0;
        check("R2 pdb low", pdb, 0);
        check("R2 endll low", endll, 0);
        check("R2 done", done, 1);
        check("R2 not busy", busy, 0);
        @(negedge clk);
        check("R2 done pulse", done, 0);
        check("R2 still idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 pdb", pdb, 0);
        check("R10 endll", endll, 0);
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 err", err, 0);
        check("R10 code", err_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", {busy, done, err, pdb}, 0);

        for (int v = 0; v < 4; v++) begin
            run_on(VEC[v][3], VEC[v][2], VEC[v][1:0], 1'b0, 1'b0);
        end
        run_off(1'b0);
        run_on(1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
        run_on(1'b1, 1'b1, 2'b00, 1'b0, 1'b1);
        run_off(1'b1);
        run_off(1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule